// File: doc/BRIEF.md
# Mixed-Radix Digit-Serial Subtractor

The block subtracts two six-digit numbers one digit pair at a time and returns P = A - B - bin. Digit 0 has a programmable radix M (1 to 16), and digits 1 to 5 are decimal, so a value is (n5·10^4 + n4·10^3 + n3·10^2 + n2·10 + n1)·M + n0. A source outside the block presents the digit pairs in fetch order, least significant first. Each pair comes on two active-low 4-bit buses, qualified by a strobe and a digit index. The borrow-in comes on a serial input with the index-0 strobe.

A stored borrow ripples from each digit to the next. When the whole difference is negative, the final borrow is discarded, which leaves the result already wrapped by M·10^5. The six result digits are held in registers. A leading-digit finder reports the highest non-zero digit among n5..n2 and its position, which is the value a downstream counter is preset from.

Top module: `mrx_digit_sub`

## Requirements
- R1: After reset, res_o is all zero, done_o and dig_err_o are 0, lead_zero_o is 1, and lead_dig_o and lead_pos_o are 0.
- R2: The buses are negative logic: the digit value is the bitwise inverse of a_n_i and of b_n_i.
- R3: The radix of digit 0 is the inverse of mod_n_i, and the code 4'b1111 (inverse 0) selects M = 16.
- R4: bin_i is used only on a strobe with index 0 (1 = borrow). Its level on strobes with other indices has no effect.
- R5: Result digit i sits at res_o[4i+3:4i]. Digit 0 is A0 - B0 - borrow modulo M, digits 1..5 are modulo 10, and a negative digit difference passes a borrow to the next digit.
- R6: After a frame of indices 0..5 with in-range digits, res_o holds (A - B - bin) modulo M·10^5.
- R7: done_o is high for exactly the one cycle that follows the clock edge that accepts the index-5 strobe.
- R8: Without an accepted strobe, res_o does not change. Strobes with index 6 or 7 are ignored.
- R9: lead_dig_o is the highest non-zero digit among result digits 5..2, and lead_pos_o is its index (2..5).
- R10: If result digits 5..2 are all zero, lead_dig_o = 0, lead_pos_o = 0 and lead_zero_o = 1.
- R11: dig_err_o goes high when a digit of the frame is not below its radix (M for digit 0, 10 above it). The flag restarts on each index-0 strobe and holds until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dig_vld_i | input | 1 | Digit pair strobe |
| dig_idx_i | input | 3 | Index of the presented digit pair |
| a_n_i | input | 4 | Minuend digit, active low |
| b_n_i | input | 4 | Subtrahend digit, active low |
| bin_i | input | 1 | Serial borrow-in, sampled at index 0 |
| mod_n_i | input | 4 | Radix code for digit 0, active low |
| res_o | output | 24 | Six result digits, digit i at bits 4i+3:4i |
| done_o | output | 1 | One-cycle pulse after the last digit |
| lead_dig_o | output | 4 | Leading non-zero digit among n5..n2 |
| lead_pos_o | output | 3 | Index of that digit |
| lead_zero_o | output | 1 | n5..n2 are all zero |
| dig_err_o | output | 1 | Out-of-range digit in the current frame |

## Verification
The bench targets the borrow-in with A = B = 0 at M = 16. A design that mishandled the wrap or the code-to-16 mapping would give something other than fifteen followed by five nines. Equal operands with borrow noise on the indices above 0 catch a borrow input that leaks past digit 0. A lone non-zero digit at position 2 and an all-zero upper field check the two ends of the leading-digit search, where an off-by-one scan would report the wrong position or clear the zero flag. Out-of-range digits in both radix domains, followed by a clean frame, show whether the error flag is missing, or sticky across frames. Index-6 strobes check that stray strobes cannot overwrite a stored digit.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int unsigned DIG_W   = 4;
  localparam int unsigned NUM_DIG = 6;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned LEAD_LO = 2;
  localparam int unsigned RAD_W   = DIG_W + 1;

  // active-low radix code; all ones on the pins means full 2^DIG_W
  function automatic logic [RAD_W-1:0] radix_decode(input logic [DIG_W-1:0] code_n);
    logic [DIG_W-1:0] v;
    v = ~code_n;
    return (v == '0) ? RAD_W'(1 << DIG_W) : RAD_W'(v);
  endfunction
endpackage

// File: rtl/mrx_digit_cell.sv
module mrx_digit_cell #(
  parameter int unsigned DIG_W = 4,
  parameter int unsigned RAD_W = DIG_W + 1
) (
  input  logic [DIG_W-1:0] a_n_i,
  input  logic [DIG_W-1:0] b_n_i,
  input  logic             brw_i,
  input  logic [RAD_W-1:0] radix_i,
  output logic [DIG_W-1:0] diff_o,
  output logic             brw_o,
  output logic             err_o
);
  localparam int unsigned T_W = RAD_W + 1;

  logic [DIG_W-1:0] a_v, b_v;
  logic [T_W-1:0]   t_raw, t_fix;

  always_comb begin
    a_v    = ~a_n_i;
    b_v    = ~b_n_i;
    t_raw  = T_W'(a_v) - T_W'(b_v) - T_W'(brw_i);
    brw_o  = t_raw[T_W-1];
    t_fix  = brw_o ? t_raw + T_W'(radix_i) : t_raw;
    diff_o = t_fix[DIG_W-1:0];
    err_o  = (RAD_W'(a_v) >= radix_i) || (RAD_W'(b_v) >= radix_i);
  end
endmodule

// File: rtl/mrx_lead_find.sv
module mrx_lead_find #(
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned NUM_DIG = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned LEAD_LO = 2
) (
  input  logic [NUM_DIG*DIG_W-1:0] res_i,
  output logic [DIG_W-1:0]         lead_dig_o,
  output logic [IDX_W-1:0]         lead_pos_o,
  output logic                     lead_zero_o
);
  // ascending scan: the highest non-zero digit is written last
  always_comb begin
    lead_dig_o  = '0;
    lead_pos_o  = '0;
    lead_zero_o = 1'b1;
    for (int i = LEAD_LO; i < NUM_DIG; i++) begin
      if (res_i[i*DIG_W +: DIG_W] != '0) begin
        lead_dig_o  = res_i[i*DIG_W +: DIG_W];
        lead_pos_o  = IDX_W'(i);
        lead_zero_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mrx_digit_sub.sv
module mrx_digit_sub #(
  parameter int unsigned DIG_W   = mrx_pkg::DIG_W,
  parameter int unsigned NUM_DIG = mrx_pkg::NUM_DIG,
  parameter int unsigned IDX_W   = mrx_pkg::IDX_W,
  parameter int unsigned LEAD_LO = mrx_pkg::LEAD_LO
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dig_vld_i,
  input  logic [IDX_W-1:0]         dig_idx_i,
  input  logic [DIG_W-1:0]         a_n_i,
  input  logic [DIG_W-1:0]         b_n_i,
  input  logic                     bin_i,
  input  logic [DIG_W-1:0]         mod_n_i,
  output logic [NUM_DIG*DIG_W-1:0] res_o,
  output logic                     done_o,
  output logic [DIG_W-1:0]         lead_dig_o,
  output logic [IDX_W-1:0]         lead_pos_o,
  output logic                     lead_zero_o,
  output logic                     dig_err_o
);
  localparam int unsigned RAD_W = DIG_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIG - 1);

  logic             take, first, brw_q, brw_in, brw_out, cell_err, done_q, err_q;
  logic [RAD_W-1:0] radix_sel;
  logic [DIG_W-1:0] cell_diff;
  logic [DIG_W-1:0] res_q [NUM_DIG];

  assign take      = dig_vld_i && (dig_idx_i < IDX_W'(NUM_DIG));
  assign first     = (dig_idx_i == '0);
  assign brw_in    = first ? bin_i : brw_q;
  assign radix_sel = first ? mrx_pkg::radix_decode(mod_n_i) : RAD_W'(10);

  mrx_digit_cell #(.DIG_W(DIG_W), .RAD_W(RAD_W)) i_cell (
    .a_n_i   (a_n_i),
    .b_n_i   (b_n_i),
    .brw_i   (brw_in),
    .radix_i (radix_sel),
    .diff_o  (cell_diff),
    .brw_o   (brw_out),
    .err_o   (cell_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brw_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= take && (dig_idx_i == LAST_IDX);
      if (take) begin
        brw_q <= brw_out;
        err_q <= first ? cell_err : (err_q | cell_err);
      end
    end
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               res_q[g] <= '0;
      else if (take && dig_idx_i == IDX_W'(g))   res_q[g] <= cell_diff;
    end
    assign res_o[g*DIG_W +: DIG_W] = res_q[g];
  end

  mrx_lead_find #(
    .DIG_W(DIG_W), .NUM_DIG(NUM_DIG), .IDX_W(IDX_W), .LEAD_LO(LEAD_LO)
  ) i_lead (
    .res_i       (res_o),
    .lead_dig_o  (lead_dig_o),
    .lead_pos_o  (lead_pos_o),
    .lead_zero_o (lead_zero_o)
  );

  assign done_o    = done_q;
  assign dig_err_o = err_q;
endmodule

// File: rtl/mrx_digit_sub_chk.sv
module mrx_digit_sub_chk #(
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned NUM_DIG = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned LEAD_LO = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     dig_vld_i,
  input logic [IDX_W-1:0]         dig_idx_i,
  input logic [NUM_DIG*DIG_W-1:0] res_o,
  input logic                     done_o,
  input logic [DIG_W-1:0]         lead_dig_o,
  input logic [IDX_W-1:0]         lead_pos_o,
  input logic                     lead_zero_o,
  input logic                     dig_err_o
);
  logic acc, acc_last;
  assign acc      = dig_vld_i && (dig_idx_i < IDX_W'(NUM_DIG));
  assign acc_last = dig_vld_i && (dig_idx_i == IDX_W'(NUM_DIG - 1));

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_last |=> done_o);
  a_r7_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(acc_last));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(res_o));
  a_r10_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_zero_o |-> (res_o[NUM_DIG*DIG_W-1:LEAD_LO*DIG_W] == '0) && (lead_pos_o == '0));
  a_r9_lead_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lead_zero_o |-> (lead_dig_o != '0) && (lead_pos_o >= IDX_W'(LEAD_LO)));

  for (genvar g = 1; g < NUM_DIG; g++) begin : g_rng
    a_r5_dec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !dig_err_o) |-> (res_o[g*DIG_W +: DIG_W] <= DIG_W'(9)));
  end
endmodule

bind mrx_digit_sub mrx_digit_sub_chk #(
  .DIG_W(DIG_W), .NUM_DIG(NUM_DIG), .IDX_W(IDX_W), .LEAD_LO(LEAD_LO)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dig_vld_i   (dig_vld_i),
  .dig_idx_i   (dig_idx_i),
  .res_o       (res_o),
  .done_o      (done_o),
  .lead_dig_o  (lead_dig_o),
  .lead_pos_o  (lead_pos_o),
  .lead_zero_o (lead_zero_o),
  .dig_err_o   (dig_err_o)
);

// File: tb/test_mrx_digit_sub.sv
`timescale 1ns/1ps
module test_mrx_digit_sub;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        vld = 1'b0, bin = 1'b0;
  logic [2:0]  idx = '0;
  logic [3:0]  a_n = 4'hf, b_n = 4'hf, mod_n = 4'h0;
  logic [23:0] res;
  logic        done, lzero, err;
  logic [3:0]  ldig;
  logic [2:0]  lpos;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  mrx_digit_sub i_mrx_digit_sub (
    .clk_i(clk), .rst_ni(rst_n), .dig_vld_i(vld), .dig_idx_i(idx),
    .a_n_i(a_n), .b_n_i(b_n), .bin_i(bin), .mod_n_i(mod_n),
    .res_o(res), .done_o(done), .lead_dig_o(ldig), .lead_pos_o(lpos),
    .lead_zero_o(lzero), .dig_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint val_of(input int d[6], input int m);
    return longint'(d[5]*10000 + d[4]*1000 + d[3]*100 + d[2]*10 + d[1]) * m + d[0];
  endfunction

  function automatic logic [23:0] exp_res(input int a[6], input int b[6], input int bi, input int m);
    longint p, q;
    logic [23:0] r;
    p = val_of(a, m) - val_of(b, m) - bi;
    if (p < 0) p = p + longint'(m) * 100000;
    r[3:0] = 4'(p % m);
    q = p / m;
    for (int i = 1; i < 6; i++) begin
      r[i*4 +: 4] = 4'(q % 10);
      q = q / 10;
    end
    return r;
  endfunction

  task automatic send(input int i, input int av, input int bv, input logic bi);
    @(negedge clk);
    vld = 1'b1; idx = 3'(i); a_n = ~4'(av); b_n = ~4'(bv); bin = bi;
    @(negedge clk);
    vld = 1'b0; bin = 1'b0;
  endtask

  // bin0 drives index 0; noise drives bin_i on the other indices
  task automatic frame(input int a[6], input int b[6], input int bin0, input int m,
                       input logic noise);
    mod_n = ~4'(m % 16);
    for (int i = 0; i < 6; i++) send(i, a[i], b[i], (i == 0) ? 1'(bin0) : noise);
  endtask

  task automatic chk_frame(input int a[6], input int b[6], input int bin0, input int m);
    logic [23:0] e;
    logic [3:0] ed;
    logic [2:0] ep;
    e = exp_res(a, b, bin0, m);
    ed = '0; ep = '0;
    for (int i = 2; i < 6; i++) if (e[i*4 +: 4] != 0) begin ed = e[i*4 +: 4]; ep = 3'(i); end
    chk("R6 result", res, e);
    chk("R7 done pulse", done, 1);
    chk("R9 lead digit", ldig, ed);
    chk("R9 lead pos", lpos, ep);
    chk("R10 zero flag", lzero, (ed == 0));
    chk("R11 no error", err, 0);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a[6], b[6], z[6];
    int m, bi;
    void'($urandom(32'h5eed_1234));
    z = '{0, 0, 0, 0, 0, 0};
    repeat (3) @(negedge clk);
    // R1
    chk("R1 res", res, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 lzero", lzero, 1); chk("R1 ldig", ldig, 0); chk("R1 lpos", lpos, 0);
    rst_n = 1'b1;

    // R3 R6: 0 - 0 - 1 with code for 16 wraps to all-max digits
    frame(z, z, 1, 16, 1'b0);
    chk("R3 R6 wrap", res, 24'h999_99f);
    chk("R9 wrap lead", ldig, 9);
    @(negedge clk);

    // R4 R10: equal operands, borrow noise above index 0
    a = '{3, 7, 2, 0, 5, 1};
    frame(a, a, 0, 8, 1'b1);
    chk("R4 borrow noise ignored", res, 0);
    chk("R10 zero lead", lzero, 1);
    chk("R10 zero pos", lpos, 0);
    @(negedge clk);

    // R9: only digit 2 non-zero
    a = '{0, 0, 3, 0, 0, 0};
    frame(a, z, 0, 10, 1'b0);
    chk_frame(a, z, 0, 10);

    // R2 R5: single digit borrow ripple (0 - 1 in digit 0, M=5)
    a = '{0, 4, 0, 0, 0, 1}; b = '{1, 0, 0, 0, 0, 0};
    frame(a, b, 0, 5, 1'b0);
    chk("R5 ripple", res, 24'h100_034);
    chk("R2 inverse buses", res[3:0], 4);
    @(negedge clk);

    // R8: index 6 strobe and idle cycles leave result
    send(6, 9, 0, 1'b1);
    chk("R8 idx6 ignored", res, 24'h100_034);
    chk("R8 no done", done, 0);
    repeat (3) @(negedge clk);
    chk("R8 idle hold", res, 24'h100_034);

    // R11: decimal digit out of range
    a = '{0, 0, 12, 0, 0, 0};
    frame(a, z, 0, 10, 1'b0);
    chk("R11 decimal err", err, 1);
    @(negedge clk);
    // R11: digit 0 not below M
    a = '{7, 0, 0, 0, 0, 0};
    frame(a, z, 0, 5, 1'b0);
    chk("R11 radix err", err, 1);
    @(negedge clk);
    // R11: clean frame clears
    a = '{2, 1, 0, 0, 0, 0};
    frame(a, z, 0, 5, 1'b0);
    chk("R11 cleared", err, 0);
    @(negedge clk);

    // random frames
    for (int n = 0; n < 60; n++) begin
      m = int'($urandom_range(16, 1));
      a[0] = int'($urandom_range(m - 1, 0));
      b[0] = int'($urandom_range(m - 1, 0));
      for (int i = 1; i < 6; i++) begin
        a[i] = int'($urandom_range(9, 0));
        b[i] = int'($urandom_range(9, 0));
      end
      bi = int'($urandom_range(1, 0));
      frame(a, b, bi, m, 1'($urandom_range(1, 0)));
      chk_frame(a, b, bi, m);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule